// File: doc/BRIEF.md
# Byte-Oriented Register ALU

This block is the execute stage for the byte-wide file register operations of a small 8-bit accumulator processor. Each cycle it receives one 16-bit instruction word, together with the working register value, the 8-bit file operand already read for that instruction, and the current status flags. It is purely combinational, so a surrounding pipeline can register its outputs at whatever point suits it.

It decodes the instruction. It then returns the 8-bit result, a write enable, and the target of the write (working register or file register). It also returns a complete next flag vector, with a mask that shows which flags the instruction actually updates. For the compare, test and counting-skip instructions it raises a skip request. The multiply instruction delivers a 16-bit product on its own output. Any upper opcode not in the map is reported as illegal, and nothing is written.

The file address (low byte) and the access bit (bit 8) pass straight through for the register file logic. Flag vector bit order everywhere is: bit 0 carry (for subtraction, 1 means no borrow), bit 1 digit carry, bit 2 zero, bit 3 overflow, bit 4 negative.

Top module: `file_op_alu`

## Requirements
- R1: `addr` equals `instr[7:0]` and `access` equals `instr[8]` for every instruction word.
- R2: For opcodes selected by the upper six bits (`instr[15:10]`), `wr_en`=1 and `dest_f`=`instr[9]` (0 selects the working register, 1 the file register). Clear, set, negate and move-W-to-file always write the file register.
- R3: Add (`001001`), add with carry (`001000`), increment (`001010`) and decrement (`000001`) produce f+W, f+W+C, f+1 and f-1. They update C, DC, Z, OV and N, where OV is signed overflow.
- R4: Subtract W from f (`010111`) gives f-W. Subtract W from f with borrow (`010110`) gives f-W-(1-C). Subtract f from W with borrow (`010101`) gives W-f-(1-C). Negate (7-bit `0110110`) gives 0-f. C is set when no borrow occurs, DC when no borrow occurs out of the low nibble, and all five flags are updated.
- R5: AND (`000101`), IOR (`000100`), XOR (`000110`), complement (`000111`) and move f (`010100`) update only Z and N. Swap nibbles (`001110`) exchanges the nibbles of f and updates no flag.
- R6: Rotate left/right through carry (`001101`/`001100`) shift C in and the outgoing bit into C, updating C, Z, N. Rotate left/right without carry (`010001`/`010000`) wrap the outgoing bit around and update only Z, N.
- R7: Clear (`0110101`) writes 0 and sets only Z. Set (`0110100`) writes 0xFF and move W to file (`0110111`) writes W, both with no flag update.
- R8: Compare-skip instructions do not write and leave all flags unchanged. Equal (`0110001`), greater (`0110010`) and less (`0110000`) request a skip when f is equal to, unsigned greater than, or unsigned less than W. Test (`0110011`) requests a skip when f is 0.
- R9: Decrement-skip-zero (`001011`) and increment-skip-zero (`001111`) write f-1 / f+1 and skip when that result is 0. Decrement-skip-nonzero (`010011`) and increment-skip-nonzero (`010010`) do the same and skip when it is non-zero. None of the four changes a flag.
- R10: Multiply (7-bit `0000001`) raises `prod_we` with `product` = W*f as an unsigned 16-bit value, and has no result write and no flag update.
- R11: Any other upper opcode raises `illegal` with `wr_en`, `prod_we`, `skip` and every `flag_we` bit low.
- R12: Every flag whose `flag_we` bit is 0 appears on `flags_out` unchanged from `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| wreg | input | 8 | Working register value |
| fdata | input | 8 | File register operand |
| flags_in | input | 5 | Current flags {N,OV,Z,DC,C} |
| result | output | 8 | Value to write back |
| wr_en | output | 1 | Result write request |
| dest_f | output | 1 | 1 = file register, 0 = working register |
| flags_out | output | 5 | Next flag vector |
| flag_we | output | 5 | Per-flag update mask |
| skip | output | 1 | Skip the next instruction |
| product | output | 16 | Unsigned W*f |
| prod_we | output | 1 | Product write request (multiply) |
| addr | output | 8 | File address pass-through |
| access | output | 1 | Access bit pass-through |
| illegal | output | 1 | Unrecognised opcode |

## Verification
Some properties are checked by the assertions on every evaluation. An illegal opcode stays silent. Unmasked flags pass through unchanged. A skip request never comes with a flag update. Multiply never writes the result. Clear always yields a zero result with Z set. The arithmetic itself can only be shown by the bench's scenarios, which compare against an integer model: the carry, digit-carry and overflow values of each add and subtract form, the rotate bit movement, the skip conditions at the 0x00/0xFF wrap points and the unsigned ordering of the compares.

// File: rtl/file_op_alu.sv
module file_op_alu (
  input  logic [15:0] instr,
  input  logic [7:0]  wreg,
  input  logic [7:0]  fdata,
  input  logic [4:0]  flags_in,
  output logic [7:0]  result,
  output logic        wr_en,
  output logic        dest_f,
  output logic [4:0]  flags_out,
  output logic [4:0]  flag_we,
  output logic        skip,
  output logic [15:0] product,
  output logic        prod_we,
  output logic [7:0]  addr,
  output logic        access,
  output logic        illegal
);
  localparam int FC = 0, FDC = 1, FZ = 2, FOV = 3, FN = 4;
  localparam logic [4:0] M_ALL = 5'b11111, M_ZN = 5'b10100, M_CZN = 5'b10101, M_Z = 5'b00100;
  localparam logic [6:0] OP_CLR = 7'b0110101, OP_SET = 7'b0110100, OP_NEG = 7'b0110110,
                         OP_MOVW = 7'b0110111, OP_MUL = 7'b0000001, OP_CPEQ = 7'b0110001,
                         OP_CPGT = 7'b0110010, OP_CPLT = 7'b0110000, OP_TST = 7'b0110011;

  logic [5:0] op6;
  logic [6:0] op7;
  logic       c_in;
  logic [7:0] a_op, b_op, res;
  logic       cin;
  logic [8:0] sum;
  logic [4:0] lo, nf, mask;
  logic       ovf;

  assign op6     = instr[15:10];
  assign op7     = instr[15:9];
  assign c_in    = flags_in[FC];
  assign addr    = instr[7:0];
  assign access  = instr[8];
  assign product = 16'(wreg) * 16'(fdata);

  always_comb begin
    a_op = fdata;
    b_op = 8'h00;
    cin  = 1'b0;
    case (op6)
      6'b001001: b_op = wreg;
      6'b001000: begin b_op = wreg; cin = c_in; end
      6'b010111: begin b_op = ~wreg; cin = 1'b1; end
      6'b010110: begin b_op = ~wreg; cin = c_in; end
      6'b010101: begin a_op = wreg; b_op = ~fdata; cin = c_in; end
      6'b001010, 6'b001111, 6'b010010: cin = 1'b1;
      6'b000001, 6'b001011, 6'b010011: b_op = 8'hFF;
      default: if (op7 == OP_NEG) begin a_op = 8'h00; b_op = ~fdata; cin = 1'b1; end
    endcase
  end

  assign lo  = {1'b0, a_op[3:0]} + {1'b0, b_op[3:0]} + {4'b0, cin};
  assign sum = {1'b0, a_op} + {1'b0, b_op} + {8'b0, cin};
  assign ovf = (a_op[7] == b_op[7]) && (sum[7] != a_op[7]);

  always_comb begin
    res     = 8'h00;
    wr_en   = 1'b0;
    dest_f  = instr[9];
    nf      = flags_in;
    mask    = 5'b0;
    skip    = 1'b0;
    prod_we = 1'b0;
    illegal = 1'b0;
    case (op6)
      6'b001001, 6'b001000, 6'b010111, 6'b010110, 6'b010101, 6'b001010, 6'b000001: begin
        res = sum[7:0]; wr_en = 1'b1; mask = M_ALL;
        nf[FC] = sum[8]; nf[FDC] = lo[4]; nf[FOV] = ovf;
      end
      6'b001011, 6'b001111: begin res = sum[7:0]; wr_en = 1'b1; skip = (sum[7:0] == 8'h00); end
      6'b010011, 6'b010010: begin res = sum[7:0]; wr_en = 1'b1; skip = (sum[7:0] != 8'h00); end
      6'b000101: begin res = wreg & fdata; wr_en = 1'b1; mask = M_ZN; end
      6'b000100: begin res = wreg | fdata; wr_en = 1'b1; mask = M_ZN; end
      6'b000110: begin res = wreg ^ fdata; wr_en = 1'b1; mask = M_ZN; end
      6'b000111: begin res = ~fdata; wr_en = 1'b1; mask = M_ZN; end
      6'b010100: begin res = fdata; wr_en = 1'b1; mask = M_ZN; end
      6'b001110: begin res = {fdata[3:0], fdata[7:4]}; wr_en = 1'b1; end
      6'b001101: begin res = {fdata[6:0], c_in}; nf[FC] = fdata[7]; wr_en = 1'b1; mask = M_CZN; end
      6'b001100: begin res = {c_in, fdata[7:1]}; nf[FC] = fdata[0]; wr_en = 1'b1; mask = M_CZN; end
      6'b010001: begin res = {fdata[6:0], fdata[7]}; wr_en = 1'b1; mask = M_ZN; end
      6'b010000: begin res = {fdata[0], fdata[7:1]}; wr_en = 1'b1; mask = M_ZN; end
      default: begin
        case (op7)
          OP_CLR:  begin res = 8'h00; wr_en = 1'b1; dest_f = 1'b1; mask = M_Z; end
          OP_SET:  begin res = 8'hFF; wr_en = 1'b1; dest_f = 1'b1; end
          OP_MOVW: begin res = wreg;  wr_en = 1'b1; dest_f = 1'b1; end
          OP_NEG:  begin
            res = sum[7:0]; wr_en = 1'b1; dest_f = 1'b1; mask = M_ALL;
            nf[FC] = sum[8]; nf[FDC] = lo[4]; nf[FOV] = ovf;
          end
          OP_MUL:  prod_we = 1'b1;
          OP_CPEQ: skip = (fdata == wreg);
          OP_CPGT: skip = (fdata > wreg);
          OP_CPLT: skip = (fdata < wreg);
          OP_TST:  skip = (fdata == 8'h00);
          default: illegal = 1'b1;
        endcase
      end
    endcase
    if (mask[FZ]) nf[FZ] = (res == 8'h00);
    if (mask[FN]) nf[FN] = res[7];
  end

  assign result    = res;
  assign flags_out = nf;
  assign flag_we   = mask;

  always_comb begin
    if (illegal) AST_ILLEGAL_SILENT: assert (!wr_en && !prod_we && !skip && flag_we == 5'b0); // R11
    for (int i = 0; i < 5; i++)
      if (!flag_we[i]) AST_FLAG_HOLD: assert (flags_out[i] == flags_in[i]); // R12
    if (skip) AST_SKIP_NO_FLAGS: assert (flag_we == 5'b0); // R8
    if (prod_we) AST_MUL_NO_WRITE: assert (!wr_en && flag_we == 5'b0); // R10
    if (op7 == OP_CLR) AST_CLEAR_ZERO: assert (result == 8'h00 && flags_out[FZ] && wr_en); // R7
  end
endmodule

// File: tb/file_op_alu_tb_top.sv
`timescale 1ns/1ps
module file_op_alu_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] instr = '0;
  logic [7:0]  wreg = '0, fdata = '0;
  logic [4:0]  flags_in = '0;
  logic [7:0]  result;
  logic        wr_en, dest_f, skip, prod_we, access, illegal;
  logic [4:0]  flags_out, flag_we;
  logic [15:0] product;
  logic [7:0]  addr;

  int total = 0, bad = 0;
  bit done = 0;

  file_op_alu dut_i (.instr(instr), .wreg(wreg), .fdata(fdata), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .dest_f(dest_f), .flags_out(flags_out), .flag_we(flag_we),
    .skip(skip), .product(product), .prod_we(prod_we), .addr(addr), .access(access),
    .illegal(illegal));

  task automatic chk(string tag, bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {ov, dc, c, r[7:0]}
  function automatic logic [10:0] m_add(int a, int b, int ci);
    int s = a + b + ci;
    int sv = sx(a) + sx(b) + ci;
    bit dc = ((a & 15) + (b & 15) + ci) > 15;
    return {(sv > 127 || sv < -128), dc, (s > 255), 8'(s)};
  endfunction

  function automatic logic [10:0] m_sub(int a, int b, int bw);
    int s = a - b - bw;
    int sv = sx(a) - sx(b) - bw;
    bit dc = (a & 15) >= ((b & 15) + bw);
    return {(sv > 127 || sv < -128), dc, (a >= b + bw), 8'(s)};
  endfunction

  task automatic run(input logic [15:0] ins, input logic [7:0] w, input logic [7:0] f,
                     input logic [4:0] fl);
    logic [7:0] r; logic [4:0] fo, fm; logic [10:0] ar;
    bit we, df, sk, pw, ill, ar_used;
    string tag;
    int wi = w, fi = f, c = fl[0];
    logic [5:0] o6 = ins[15:10];
    logic [6:0] o7 = ins[15:9];
    r = 0; fo = fl; fm = 0; we = 0; df = ins[9]; sk = 0; pw = 0; ill = 0; ar = 0; ar_used = 0;
    tag = "R11";
    case (o6)
      6'b001001: begin ar = m_add(fi, wi, 0); ar_used = 1; tag = "R3"; end
      6'b001000: begin ar = m_add(fi, wi, c); ar_used = 1; tag = "R3"; end
      6'b001010: begin ar = m_add(fi, 1, 0); ar_used = 1; tag = "R3"; end
      6'b000001: begin ar = m_sub(fi, 1, 0); ar_used = 1; tag = "R3"; end
      6'b010111: begin ar = m_sub(fi, wi, 0); ar_used = 1; tag = "R4"; end
      6'b010110: begin ar = m_sub(fi, wi, 1 - c); ar_used = 1; tag = "R4"; end
      6'b010101: begin ar = m_sub(wi, fi, 1 - c); ar_used = 1; tag = "R4"; end
      6'b001011: begin r = 8'(fi - 1); we = 1; sk = (r == 0); tag = "R9"; end
      6'b001111: begin r = 8'(fi + 1); we = 1; sk = (r == 0); tag = "R9"; end
      6'b010011: begin r = 8'(fi - 1); we = 1; sk = (r != 0); tag = "R9"; end
      6'b010010: begin r = 8'(fi + 1); we = 1; sk = (r != 0); tag = "R9"; end
      6'b000101: begin r = w & f; we = 1; fm = 5'b10100; tag = "R5"; end
      6'b000100: begin r = w | f; we = 1; fm = 5'b10100; tag = "R5"; end
      6'b000110: begin r = w ^ f; we = 1; fm = 5'b10100; tag = "R5"; end
      6'b000111: begin r = 8'(255 - fi); we = 1; fm = 5'b10100; tag = "R5"; end
      6'b010100: begin r = f; we = 1; fm = 5'b10100; tag = "R5"; end
      6'b001110: begin r = 8'((fi % 16) * 16 + fi / 16); we = 1; tag = "R5"; end
      6'b001101: begin r = 8'(fi * 2 + c); fo[0] = fi >= 128; we = 1; fm = 5'b10101; tag = "R6"; end
      6'b001100: begin r = 8'(fi / 2 + c * 128); fo[0] = fi % 2; we = 1; fm = 5'b10101; tag = "R6"; end
      6'b010001: begin r = 8'(fi * 2 + fi / 128); we = 1; fm = 5'b10100; tag = "R6"; end
      6'b010000: begin r = 8'(fi / 2 + (fi % 2) * 128); we = 1; fm = 5'b10100; tag = "R6"; end
      default: begin
        case (o7)
          7'b0110101: begin r = 0; we = 1; df = 1; fm = 5'b00100; tag = "R7"; end
          7'b0110100: begin r = 8'hFF; we = 1; df = 1; tag = "R7"; end
          7'b0110111: begin r = w; we = 1; df = 1; tag = "R7"; end
          7'b0110110: begin ar = m_sub(0, fi, 0); ar_used = 1; df = 1; tag = "R4"; end
          7'b0000001: begin pw = 1; tag = "R10"; end
          7'b0110001: begin sk = (fi == wi); tag = "R8"; end
          7'b0110010: begin sk = (fi > wi); tag = "R8"; end
          7'b0110000: begin sk = (fi < wi); tag = "R8"; end
          7'b0110011: begin sk = (fi == 0); tag = "R8"; end
          default: ill = 1;
        endcase
      end
    endcase
    if (ar_used) begin
      r = ar[7:0]; fo[0] = ar[8]; fo[1] = ar[9]; fo[3] = ar[10]; fm = 5'b11111; we = 1;
    end
    if (fm[2]) fo[2] = (r == 0);
    if (fm[4]) fo[4] = r[7];

    @(posedge clk);
    instr = ins; wreg = w; fdata = f; flags_in = fl;
    @(negedge clk);
    chk("R1", addr == ins[7:0] && access == ins[8], "addr/access", {access, addr}, {ins[8], ins[7:0]});
    chk(tag, wr_en == we, "wr_en", wr_en, we);
    if (we) begin
      chk(tag, result == r, "result", result, r);
      chk("R2", dest_f == df, "dest_f", dest_f, df);
    end
    chk(tag, flag_we == fm, "flag_we", flag_we, fm);
    chk(tag, flags_out == fo, "flags_out", flags_out, fo);
    for (int i = 0; i < 5; i++)
      if (!fm[i]) chk("R12", flags_out[i] == fl[i], "held flag", flags_out[i], fl[i]);
    chk(tag, skip == sk, "skip", skip, sk);
    chk(tag, prod_we == pw, "prod_we", prod_we, pw);
    if (pw) chk("R10", product == 16'(wi * fi), "product", product, wi * fi);
    chk("R11", illegal == ill, "illegal", illegal, ill);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    // initial all-zero word is an illegal opcode (R11)
    @(negedge clk);
    chk("R11", illegal && !wr_en && !skip && !prod_we && flag_we == 0, "zero word", illegal, 1);
    // directed corners
    run({6'b001001, 2'b10, 8'h12}, 8'h80, 8'h80, 5'b00000); // R3 C,OV,Z
    run({6'b001000, 2'b01, 8'h34}, 8'h0F, 8'h00, 5'b00001); // R3 DC via carry in
    run({6'b001010, 2'b10, 8'h01}, 8'h00, 8'h7F, 5'b00000); // R3 inc OV
    run({6'b000001, 2'b00, 8'h02}, 8'h00, 8'h00, 5'b11111); // R3 dec 0 borrow
    run({6'b010111, 2'b10, 8'h03}, 8'h55, 8'h55, 5'b00000); // R4 equal -> Z,C
    run({6'b010110, 2'b10, 8'h03}, 8'h01, 8'h01, 5'b00000); // R4 borrow in
    run({6'b010101, 2'b00, 8'h03}, 8'h10, 8'h01, 5'b00001); // R4 subfwb
    run({7'b0110110, 1'b0, 8'h04}, 8'h00, 8'h80, 5'b00000); // R4 neg 0x80 OV
    run({7'b0110110, 1'b0, 8'h04}, 8'h00, 8'h00, 5'b00000); // R4 neg 0 C
    run({6'b001101, 2'b10, 8'h05}, 8'h00, 8'h80, 5'b00001); // R6 rlcf
    run({6'b001100, 2'b10, 8'h05}, 8'h00, 8'h01, 5'b00000); // R6 rrcf zero
    run({6'b001011, 2'b10, 8'h06}, 8'h00, 8'h01, 5'b01010); // R9 dec -> 0 skip
    run({6'b001111, 2'b00, 8'h06}, 8'h00, 8'hFF, 5'b00000); // R9 inc wrap skip
    run({6'b010011, 2'b10, 8'h06}, 8'h00, 8'h01, 5'b00000); // R9 no skip
    run({6'b010010, 2'b10, 8'h06}, 8'h00, 8'hFF, 5'b00000); // R9 no skip
    run({7'b0110010, 1'b0, 8'h07}, 8'h40, 8'h40, 5'b10101); // R8 gt equal
    run({7'b0110010, 1'b0, 8'h07}, 8'h7F, 8'h80, 5'b00000); // R8 unsigned gt
    run({7'b0110000, 1'b0, 8'h07}, 8'h80, 8'h7F, 5'b00000); // R8 unsigned lt
    run({7'b0110011, 1'b1, 8'h07}, 8'h12, 8'h00, 5'b11111); // R8 test zero
    run({7'b0000001, 1'b0, 8'h08}, 8'hFF, 8'hFF, 5'b10101); // R10 0xFE01
    run({7'b0110101, 1'b0, 8'h09}, 8'h33, 8'h44, 5'b11011); // R7 clear
    run({6'b001110, 2'b10, 8'h0A}, 8'h00, 8'hA5, 5'b11111); // R5 swap
    run({6'b000110, 2'b00, 8'h0B}, 8'hF0, 8'hF0, 5'b10000); // R5 xor zero
    run({6'b111111, 2'b11, 8'hFF}, 8'h01, 8'h02, 5'b10101); // R11
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ins = 16'($urandom());
      logic [7:0] w = 8'($urandom());
      logic [7:0] f = 8'($urandom());
      int sel = $urandom_range(0, 7);
      if (sel == 0) f = w;
      else if (sel == 1) f = 8'h00;
      else if (sel == 2) f = 8'hFF;
      run(ins, w, f, 5'($urandom()));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule